// File: doc/BRIEF.md
# Baseband DC Offset Corrector

This block removes a standing DC component from a stream of complex baseband samples. The stream has already been decimated, so a sample normally arrives on every other clock, although back-to-back samples are also accepted. For each of the I and Q lanes a first-order recursive averager builds an estimate of the offset. The block subtracts that estimate from the sample and clips the result to the signed sample range.

A small write-only register port selects the operating mode and sets the averager's loop gain and a pair of calibration constants. In bypass the samples go through untouched. In tracking the estimate follows the input. In hold the estimate is frozen, either at the value it had on entry or at a calibration constant that software loaded beforehand. A constant written while hold is active replaces the estimate straight away.

Top module: `dc_offset_corrector`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly two clocks later, whatever the pattern of valid samples, including back-to-back samples.
- R2: In bypass (mode code 0), each output equals its input sample unchanged, and the offset estimate keeps its value.
- R3: In tracking (mode code 1), each valid sample x updates the per-lane estimate as e += (x − e) / 2^k with an arithmetic right shift. e is held with 16 fractional bits. k is `cfg_wdata[3:0]` written at address 1.
- R4: Outside bypass, each output is the sample minus floor(e), where e is the estimate before that sample's update. The result is saturated to −32768..32767.
- R5: Entering hold (mode code 2) with no constant pending freezes both estimates at their current values while hold lasts.
- R6: A constant is written at address 2 for I and address 3 for Q, as a signed value in `cfg_wdata`. A constant written outside hold is pending. When a mode change then enters hold, the estimates become those constants. Any mode change clears the pending state.
- R7: A constant written while in hold replaces the estimate one clock later.
- R8: Returning from hold to tracking resumes the averaging from the held estimate.
- R9: A write of the reserved mode code 3 at address 0 leaves the mode unchanged.
- R10: Synchronous reset clears both estimates and both constants, selects bypass, sets k to 4 and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Corrected in-phase sample |
| out_q | output | 16 | Corrected quadrature sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 shift, 2 constant I, 3 constant Q |
| cfg_wdata | input | 16 | Register write data |

## Verification
The hardest states to reach are the two saturation limits. They need an estimate near one rail and an input at the opposite rail. The stimulus gets there by setting the shift to zero in tracking, which makes the estimate jump to a single near-rail sample. It then freezes that value with hold and applies the opposite extreme. The pending-constant path needs a set order of writes: constant, then mode change, then samples. A second ordering writes the constant while hold is already active.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;

   typedef enum logic [1:0] {
      MODE_BYPASS = 2'd0,
      MODE_TRACK  = 2'd1,
      MODE_HOLD   = 2'd2,
      MODE_RSVD   = 2'd3
   } dcoc_mode_e;

   localparam logic [1:0] ADDR_MODE  = 2'd0;
   localparam logic [1:0] ADDR_SHIFT = 2'd1;
   localparam logic [1:0] ADDR_CST_I = 2'd2;
   localparam logic [1:0] ADDR_CST_Q = 2'd3;

   localparam int NUM_LANES = 2;

endpackage

// File: rtl/dcoc_regs.sv
module dcoc_regs
   import dcoc_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int SHIFT_W     = 4,
   parameter int SHIFT_RESET = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we,
   input  logic [1:0]                 addr,
   input  logic [SAMPLE_W-1:0]        wdata,
   output dcoc_mode_e                 mode_o,
   output logic [SHIFT_W-1:0]         shift_o,
   output logic signed [SAMPLE_W-1:0] cst_i_o,
   output logic signed [SAMPLE_W-1:0] cst_q_o,
   output logic                       load_o
);

   dcoc_mode_e mode_r;
   dcoc_mode_e mode_wr;
   logic       pending_r;

   assign mode_wr = dcoc_mode_e'(wdata[1:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_r    <= MODE_BYPASS;
         shift_o   <= SHIFT_W'(SHIFT_RESET);
         cst_i_o   <= '0;
         cst_q_o   <= '0;
         pending_r <= 1'b0;
         load_o    <= 1'b0;
      end else begin
         load_o <= 1'b0;
         if (we) begin
            unique case (addr)
               ADDR_MODE: begin
                  if (mode_wr != MODE_RSVD && mode_wr != mode_r) begin
                     mode_r    <= mode_wr;
                     pending_r <= 1'b0;
                     if (mode_wr == MODE_HOLD && pending_r)
                        load_o <= 1'b1;
                  end
               end
               ADDR_SHIFT: shift_o <= wdata[SHIFT_W-1:0];
               ADDR_CST_I, ADDR_CST_Q: begin
                  if (addr == ADDR_CST_I) cst_i_o <= wdata;
                  else                    cst_q_o <= wdata;
                  if (mode_r == MODE_HOLD) load_o    <= 1'b1;
                  else                     pending_r <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign mode_o = mode_r;

endmodule

// File: rtl/dcoc_lane_est.sv
module dcoc_lane_est #(
   parameter int SAMPLE_W = 16,
   parameter int FRAC_W   = 16,
   parameter int SHIFT_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         upd,
   input  logic                         load,
   input  logic signed [SAMPLE_W-1:0]   load_val,
   input  logic [SHIFT_W-1:0]           shift,
   input  logic signed [SAMPLE_W-1:0]   x,
   output logic signed [SAMPLE_W+1:0]   est
);

   localparam int AW = SAMPLE_W + FRAC_W + 2;

   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] x_ext;
   logic signed [AW-1:0] ld_ext;
   logic signed [AW-1:0] diff;
   logic signed [AW-1:0] step;

   assign x_ext  = {{2{x[SAMPLE_W-1]}}, x, {FRAC_W{1'b0}}};
   assign ld_ext = {{2{load_val[SAMPLE_W-1]}}, load_val, {FRAC_W{1'b0}}};
   assign diff   = x_ext - acc;
   assign step   = diff >>> shift;

   always_ff @(posedge clk) begin
      if (rst)       acc <= '0;
      else if (load) acc <= ld_ext;
      else if (upd)  acc <= acc + step;
   end

   assign est = acc[AW-1:FRAC_W];

endmodule

// File: rtl/dcoc_sub_sat.sv
module dcoc_sub_sat #(
   parameter int SAMPLE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bypass,
   input  logic signed [SAMPLE_W-1:0] x,
   input  logic signed [SAMPLE_W+1:0] est,
   output logic signed [SAMPLE_W-1:0] y
);

   localparam int WD = SAMPLE_W + 3;
   localparam logic signed [SAMPLE_W-1:0] SMAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [SAMPLE_W-1:0] SMIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic signed [WD-1:0]       wide;
   logic signed [SAMPLE_W-1:0] clipped;

   assign wide = {{3{x[SAMPLE_W-1]}}, x} - {est[SAMPLE_W+1], est};

   always_comb begin
      if (wide[WD-1:SAMPLE_W-1] == {(WD-SAMPLE_W+1){wide[WD-1]}})
         clipped = wide[SAMPLE_W-1:0];
      else
         clipped = wide[WD-1] ? SMIN : SMAX;
   end

   always_ff @(posedge clk) begin
      if (rst) y <= '0;
      else     y <= bypass ? x : clipped;
   end

endmodule

// File: rtl/dc_offset_corrector.sv
module dc_offset_corrector
   import dcoc_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int FRAC_W      = 16,
   parameter int SHIFT_W     = 4,
   parameter int SHIFT_RESET = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_i,
   output logic [SAMPLE_W-1:0] out_q,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_addr,
   input  logic [SAMPLE_W-1:0] cfg_wdata
);

   localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;

   if (SAMPLE_W < 4) begin : g_chk_w
      $error("SAMPLE_W must be at least 4");
   end
   if (FRAC_W < 16) begin : g_chk_f
      $error("FRAC_W must be at least 16");
   end
   if (MAX_SHIFT > SAMPLE_W + FRAC_W) begin : g_chk_s
      $error("SHIFT_W allows shifts wider than the accumulator");
   end
   if (SHIFT_RESET > MAX_SHIFT) begin : g_chk_r
      $error("SHIFT_RESET does not fit in SHIFT_W");
   end

   dcoc_mode_e                 mode;
   logic [SHIFT_W-1:0]         shift;
   logic signed [SAMPLE_W-1:0] cst_i, cst_q;
   logic                       load;

   logic                       vld_s1;
   logic signed [SAMPLE_W-1:0] lane_in  [NUM_LANES];
   logic signed [SAMPLE_W-1:0] lane_s1  [NUM_LANES];
   logic signed [SAMPLE_W-1:0] lane_cst [NUM_LANES];
   logic signed [SAMPLE_W+1:0] est_lane [NUM_LANES];
   logic signed [SAMPLE_W-1:0] lane_out [NUM_LANES];
   logic                       upd;
   logic                       bypass;

   dcoc_regs #(
      .SAMPLE_W    (SAMPLE_W),
      .SHIFT_W     (SHIFT_W),
      .SHIFT_RESET (SHIFT_RESET)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .mode_o  (mode),
      .shift_o (shift),
      .cst_i_o (cst_i),
      .cst_q_o (cst_q),
      .load_o  (load)
   );

   assign lane_in[0]  = in_i;
   assign lane_in[1]  = in_q;
   assign lane_cst[0] = cst_i;
   assign lane_cst[1] = cst_q;
   assign upd         = vld_s1 && (mode == MODE_TRACK);
   assign bypass      = (mode == MODE_BYPASS);

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_s1    <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         vld_s1    <= in_valid;
         out_valid <= vld_s1;
      end
   end

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)           lane_s1[g] <= '0;
         else if (in_valid) lane_s1[g] <= lane_in[g];
      end

      dcoc_lane_est #(
         .SAMPLE_W (SAMPLE_W),
         .FRAC_W   (FRAC_W),
         .SHIFT_W  (SHIFT_W)
      ) u_est (
         .clk      (clk),
         .rst      (rst),
         .upd      (upd),
         .load     (load),
         .load_val (lane_cst[g]),
         .shift    (shift),
         .x        (lane_s1[g]),
         .est      (est_lane[g])
      );

      dcoc_sub_sat #(
         .SAMPLE_W (SAMPLE_W)
      ) u_sub (
         .clk    (clk),
         .rst    (rst),
         .bypass (bypass),
         .x      (lane_s1[g]),
         .est    (est_lane[g]),
         .y      (lane_out[g])
      );
   end

   assign out_i = lane_out[0];
   assign out_q = lane_out[1];

endmodule

// File: rtl/dcoc_checker.sv
module dcoc_checker
   import dcoc_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [SAMPLE_W-1:0] in_i,
   input logic                out_valid,
   input logic [SAMPLE_W-1:0] out_i,
   input dcoc_mode_e          mode,
   input logic                load,
   input logic [SAMPLE_W+1:0] est_i
);

   // R1
   valid_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);

   // R1
   valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 2));

   // R2
   bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(mode == MODE_BYPASS)) |-> out_i == $past(in_i, 2));

   // R2
   bypass_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_BYPASS && !load) |=> $stable(est_i));

   // R5
   hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_HOLD && !load) |=> $stable(est_i));

   // R9
   mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
      mode != MODE_RSVD);

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> !out_valid);

endmodule

bind dc_offset_corrector dcoc_checker #(
   .SAMPLE_W (SAMPLE_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_i      (in_i),
   .out_valid (out_valid),
   .out_i     (out_i),
   .mode      (mode),
   .load      (load),
   .est_i     (est_lane[0])
);

// File: tb/dc_offset_corrector_bench.sv
module dc_offset_corrector_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_i = '0, in_q = '0;
   logic        out_valid;
   logic [15:0] out_i, out_q;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;
   bit done    = 0;

   typedef struct {
      int    ei;
      int    eq;
      int    stamp;
      string tag;
   } exp_t;

   exp_t sb[$];

   int     mode_m;
   longint acc_m [2];
   int     shift_m;
   int     cst_m [2];
   bit     pend_m;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dc_offset_corrector u_dc_offset_corrector (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata)
   );

   function automatic int sat16(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   task automatic model_reset();
      mode_m  = 0;
      acc_m[0] = 0; acc_m[1] = 0;
      shift_m = 4;
      cst_m[0] = 0; cst_m[1] = 0;
      pend_m  = 0;
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(int xi, int xq, string tag);
      exp_t   e;
      int     xs [2];
      int     ev [2];
      xs[0] = xi; xs[1] = xq;
      for (int l = 0; l < 2; l++) begin
         if (mode_m == 0) ev[l] = xs[l];
         else ev[l] = sat16(longint'(xs[l]) - (acc_m[l] >>> 16));
         if (mode_m == 1)
            acc_m[l] = acc_m[l] + (((longint'(xs[l]) <<< 16) - acc_m[l]) >>> shift_m);
      end
      e.ei = ev[0]; e.eq = ev[1]; e.stamp = cyc; e.tag = tag;
      sb.push_back(e);
      in_valid = 1'b1;
      in_i = 16'(xi);
      in_q = 16'(xq);
      @(negedge clk);
   endtask

   task automatic cfg(int addr, int data);
      idle(3);
      case (addr)
         0: if (data != 3 && data != mode_m) begin
               if (data == 2 && pend_m) begin
                  acc_m[0] = longint'(cst_m[0]) <<< 16;
                  acc_m[1] = longint'(cst_m[1]) <<< 16;
               end
               mode_m = data;
               pend_m = 0;
            end
         1: shift_m = data & 15;
         default: begin
            cst_m[addr-2] = int'($signed(16'(data)));
            if (mode_m == 2) begin
               acc_m[0] = longint'(cst_m[0]) <<< 16;
               acc_m[1] = longint'(cst_m[1]) <<< 16;
            end else pend_m = 1;
         end
      endcase
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 16'(data);
      @(negedge clk);
      cfg_we = 1'b0;
      idle(3);
   endtask

   task automatic do_reset();
      idle(3);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      model_reset();
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic check(bit ok, string tag, int act, int exp_v);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (sb.size() == 0) begin
            check(0, "R1 unexpected output", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(cyc - e.stamp == 2, "R1 latency", cyc - e.stamp, 2);
            check(int'($signed(out_i)) == e.ei, {e.tag, " lane I"}, int'($signed(out_i)), e.ei);
            check(int'($signed(out_q)) == e.eq, {e.tag, " lane Q"}, int'($signed(out_q)), e.eq);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R10: outputs quiet after reset
      check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
      check(out_i == 16'd0, "R10 out_i after reset", int'(out_i), 0);

      // R2: bypass, alternate-cycle samples, extremes
      send(123, -456, "R2 bypass"); idle(1);
      send(32767, -32768, "R2 bypass extreme"); idle(1);
      send(-32768, 32767, "R2 bypass extreme"); idle(1);
      send(0, 7, "R2 bypass"); idle(1);

      // R1: back-to-back samples in bypass
      for (int n = 0; n < 6; n++) send(n * 1000 - 2500, 300 - n * 77, "R1 burst bypass");
      idle(2);

      // R3 and R10: tracking with reset shift of 4
      cfg(0, 1);
      for (int n = 0; n < 20; n++) begin send(1600, -800, "R3 track k4"); idle(1); end
      cfg(1, 2);
      for (int n = 0; n < 10; n++) send(-2000 + n, 5000 - n * 3, "R3 track k2 burst");
      idle(2);

      // R4: saturation at both rails
      cfg(1, 0);
      send(-30000, 30000, "R4 preload"); idle(1);
      cfg(0, 2);
      send(32767, -32768, "R4 saturate"); idle(1);
      send(100, -100, "R4 no saturate"); idle(1);

      // R8: back to tracking from held value
      cfg(0, 1);
      cfg(1, 3);
      for (int n = 0; n < 4; n++) begin send(700 + n * 11, -300 - n * 5, "R8 resume track"); idle(1); end

      // R5: hold without a pending constant freezes estimates
      cfg(0, 2);
      for (int n = 0; n < 5; n++) begin send(n * 3000 - 6000, 4000 - n * 2500, "R5 hold freeze"); idle(1); end

      // R6: constant pending while tracking, then hold
      cfg(0, 1);
      send(900, 900, "R6 track before"); idle(1);
      cfg(2, 500);
      cfg(3, 16'hFD44); // -700
      send(900, 900, "R6 still tracking"); idle(1);
      cfg(0, 2);
      send(1000, -1000, "R6 constant applied"); idle(1);
      send(-32768, 32767, "R6 constant applied"); idle(1);

      // R7: constant written during hold
      cfg(2, 16'hFB2E); // -1234
      send(0, 0, "R7 immediate constant"); idle(1);
      send(32000, -5, "R7 immediate constant"); idle(1);

      // R9: reserved mode write ignored (stays in hold)
      cfg(0, 3);
      send(10, 20, "R9 reserved ignored"); idle(1);
      cfg(0, 1);
      cfg(0, 3);
      for (int n = 0; n < 3; n++) send(4444, -4444, "R9 reserved ignored track");
      idle(2);

      // R10: mid-run reset clears estimate and selects bypass
      do_reset();
      send(1234, -1234, "R10 bypass after reset"); idle(1);
      cfg(0, 1);
      send(1000, -1000, "R10 estimate cleared"); idle(1);
      send(1000, -1000, "R10 shift reset value"); idle(1);

      idle(5);
      check(sb.size() == 0, "R1 outputs missing", sb.size(), 0);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule